// File: doc/BRIEF.md
# Amplifier control and diagnostic I2C slave

This block is the two-wire serial slave for a four-channel amplifier controller. A master addresses it with a 7-bit device address followed by a direction bit. A write carries two command bytes. The slave turns them into steady control levels:

- diagnostic enable and offset-test enable;
- a gain select and an unmute bit for each of the front and rear groups;
- a clip-threshold select;
- an efficiency-mode select for each of the left and right sides.

A read returns four status bytes. Neighbouring diagnostic logic supplies these bytes as one 32-bit word, and the slave captures that word at the address acknowledge. Every read that ends with a STOP produces a one-cycle re-arm pulse. The diagnostic engines use that pulse to start their next measurement. The data just read therefore always belongs to the earlier measurement cycle.

SCL and SDA each pass through two flip-flops on the system clock before edge detection, so the bus must be much slower than the system clock. The slave pulls SDA low through `sda_oe`. The pad and the pull-up are outside the block.

Top module: `quad_amp_i2c_regs`

## Requirements
- R1: After reset all control outputs are 0 (diagnostics and offset test off, high gain, muted, lower clip threshold, efficiency mode on both sides), `sda_oe` is 0 and `rearm` is 0.
- R2: A START (SDA falling while SCL is high) restarts address reception from any state. A STOP (SDA rising while SCL is high) returns the slave to idle with SDA released.
- R3: The address byte is received MSB first. Its bits 7..1 are compared with `DEV_ADDR`, and bit 0 selects direction (0 = master writes, 1 = master reads). On a match the slave holds SDA low for the ninth clock.
- R4: On an address mismatch the slave does not acknowledge. It ignores all following bytes until the next START, and its outputs and `rearm` are unaffected.
- R5: The first write byte is acknowledged and maps bit 6 to `diag_en`, bit 5 to `offs_en`, bit 4 to `front_gain_lo`, bit 3 to `rear_gain_lo`, bit 2 to `front_unmute`, bit 1 to `rear_unmute` and bit 0 to `clip_hi`. Bit 7 is ignored.
- R6: The second write byte is acknowledged and maps bit 1 to `right_std` and bit 0 to `left_std`. Bits 7..2 are ignored.
- R7: A third or later write byte is not acknowledged and changes no output.
- R8: A read returns `diag_status[31:24]`, `[23:16]`, `[15:8]` and `[7:0]` in that order, each MSB first. The word is captured at the falling SCL edge that ends the address acknowledge, so later changes to the input do not affect the transfer.
- R9: During a read the slave releases SDA for each acknowledge bit. If the master does not acknowledge, the slave stops driving until the next START or STOP, so further clocks read as 1.
- R10: `rearm` pulses for exactly one system clock after the STOP that closes a transaction containing an acknowledged read address. Write-only and mismatched transactions produce no pulse.
- R11: A command byte cut short by a START or STOP before its eighth bit leaves the control outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line as seen at the pad |
| sda_i | input | 1 | Serial data line as seen at the pad |
| diag_status | input | 32 | Status word from the diagnostic logic, first byte in bits 31:24 |
| sda_oe | output | 1 | 1 pulls SDA low |
| diag_en | output | 1 | Diagnostics enabled |
| offs_en | output | 1 | Output offset test enabled |
| front_gain_lo | output | 1 | Front group low gain |
| rear_gain_lo | output | 1 | Rear group low gain |
| front_unmute | output | 1 | Front group unmuted |
| rear_unmute | output | 1 | Rear group unmuted |
| clip_hi | output | 1 | Higher clip-detect threshold selected |
| right_std | output | 1 | Right side in standard (not high-efficiency) mode |
| left_std | output | 1 | Left side in standard (not high-efficiency) mode |
| rearm | output | 1 | One-cycle pulse restarting the diagnostic cycles |

## Verification
The bench writes all 128 values of the first command byte, each paired with a varying second byte whose ignored upper bits are set. A slip of one position in the bit mapping, or failing to mask bit 7, shows up as a wrong control level. It changes the status input right after the read address is acknowledged, which catches a design that reads the live word rather than a captured one. It sends a third write byte, a wrong address and a byte cut short by STOP and by a repeated START; a slave that accepted these would alter its outputs or acknowledge. After an early NACK it checks that the bus reads all ones, and it counts re-arm pulses to catch a pulse that is missing, doubled, or produced by a write.

// File: rtl/quad_amp_i2c_regs.sv
module quad_amp_i2c_regs #(
  parameter logic [6:0] DEV_ADDR = 7'h3A
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        scl_i,
  input  logic        sda_i,
  input  logic [31:0] diag_status,
  output logic        sda_oe,
  output logic        diag_en,
  output logic        offs_en,
  output logic        front_gain_lo,
  output logic        rear_gain_lo,
  output logic        front_unmute,
  output logic        rear_unmute,
  output logic        clip_hi,
  output logic        right_std,
  output logic        left_std,
  output logic        rearm
);

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_AACK, S_WBYTE, S_WACK, S_RBYTE, S_RACK} st_t;

  logic [2:0]  scl_p, sda_p;
  st_t         st;
  logic [7:0]  sh;
  logic [3:0]  cnt;
  logic [1:0]  idx;
  logic [31:0] snap;
  logic [6:0]  ib1;
  logic [1:0]  ib2;
  logic        rdir, rd_pend, mack;

  wire scl_rise = scl_p[1] & ~scl_p[2];
  wire scl_fall = ~scl_p[1] & scl_p[2];
  wire bus_start = scl_p[1] & scl_p[2] & sda_p[2] & ~sda_p[1];
  wire bus_stop  = scl_p[1] & scl_p[2] & ~sda_p[2] & sda_p[1];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_p <= 3'b111;
      sda_p <= 3'b111;
    end else begin
      scl_p <= {scl_p[1:0], scl_i};
      sda_p <= {sda_p[1:0], sda_i};
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st <= S_IDLE; sh <= '0; cnt <= '0; idx <= '0; snap <= '0;
      ib1 <= '0; ib2 <= '0; rdir <= 1'b0; rd_pend <= 1'b0; mack <= 1'b0;
      rearm <= 1'b0;
    end else begin
      rearm <= 1'b0;
      if (bus_start) begin
        st  <= S_ADDR;
        cnt <= '0;
      end else if (bus_stop) begin
        st      <= S_IDLE;
        rearm   <= rd_pend;
        rd_pend <= 1'b0;
      end else begin
        case (st)
          S_ADDR, S_WBYTE:
            if (scl_rise && cnt != 4'd8) begin
              sh  <= {sh[6:0], sda_p[1]};
              cnt <= cnt + 4'd1;
            end else if (scl_fall && cnt == 4'd8) begin
              if (st == S_ADDR) begin
                if (sh[7:1] == DEV_ADDR) begin
                  st   <= S_AACK;
                  rdir <= sh[0];
                end else st <= S_IDLE;
              end else if (idx == 2'd0) begin
                ib1 <= sh[6:0];
                st  <= S_WACK;
              end else if (idx == 2'd1) begin
                ib2 <= sh[1:0];
                st  <= S_WACK;
              end else st <= S_IDLE;
            end
          S_AACK:
            if (scl_fall) begin
              cnt <= '0;
              idx <= '0;
              if (rdir) begin
                st      <= S_RBYTE;
                snap    <= {diag_status[23:0], 8'h00};
                sh      <= diag_status[31:24];
                rd_pend <= 1'b1;
              end else st <= S_WBYTE;
            end
          S_WACK:
            if (scl_fall) begin
              cnt <= '0;
              idx <= idx + 2'd1;
              st  <= S_WBYTE;
            end
          S_RBYTE:
            if (scl_fall) begin
              if (cnt == 4'd7) st <= S_RACK;
              else begin
                sh  <= {sh[6:0], 1'b0};
                cnt <= cnt + 4'd1;
              end
            end
          S_RACK:
            if (scl_rise) mack <= ~sda_p[1];
            else if (scl_fall) begin
              if (mack && idx != 2'd3) begin
                idx  <= idx + 2'd1;
                sh   <= snap[31:24];
                snap <= {snap[23:0], 8'h00};
                cnt  <= '0;
                st   <= S_RBYTE;
              end else st <= S_IDLE;
            end
          default: ;
        endcase
      end
    end

  assign sda_oe = (st == S_AACK) | (st == S_WACK) | ((st == S_RBYTE) & ~sh[7]);

  assign {diag_en, offs_en, front_gain_lo, rear_gain_lo, front_unmute, rear_unmute, clip_hi} = ib1;
  assign {right_std, left_std} = ib2;

endmodule

// File: rtl/quad_amp_i2c_regs_chk.sv
module quad_amp_i2c_regs_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_i,
  input logic       sda_i,
  input logic       sda_oe,
  input logic       rearm,
  input logic [8:0] ctrl
);

  a_r10_rearm_single: assert property (@(posedge clk) disable iff (!rst_n)
    rearm |=> !rearm);

  a_r10_rearm_after_stop: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rearm) |-> (scl_i && sda_i));

  a_r3_sda_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    $changed(sda_oe) |-> !scl_i);

  a_r5_ctrl_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    $changed(ctrl) |-> !scl_i);

endmodule

bind quad_amp_i2c_regs quad_amp_i2c_regs_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i), .sda_oe(sda_oe), .rearm(rearm),
  .ctrl({diag_en, offs_en, front_gain_lo, rear_gain_lo, front_unmute, rear_unmute,
         clip_hi, right_std, left_std})
);

// File: tb/quad_amp_i2c_regs_bench.sv
module quad_amp_i2c_regs_bench;
  localparam logic [6:0] ADDR = 7'h3A;
  localparam int Q = 6;

  logic clk = 1'b0, rst_n = 1'b0, scl_m = 1'b1, sda_m = 1'b1;
  logic [31:0] diag_status = '0;
  logic sda_oe, rearm;
  logic [8:0] ctrl;
  wire sda_bus = sda_m & ~sda_oe;
  int n_chk = 0, n_fail = 0, rearm_cnt = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  quad_amp_i2c_regs #(.DEV_ADDR(ADDR)) u_quad_amp_i2c_regs (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus), .diag_status(diag_status),
    .sda_oe(sda_oe), .diag_en(ctrl[8]), .offs_en(ctrl[7]), .front_gain_lo(ctrl[6]),
    .rear_gain_lo(ctrl[5]), .front_unmute(ctrl[4]), .rear_unmute(ctrl[3]),
    .clip_hi(ctrl[2]), .right_std(ctrl[1]), .left_std(ctrl[0]), .rearm(rearm));

  always @(posedge clk) if (rearm) rearm_cnt <= rearm_cnt + 1;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic w(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; w(Q); scl_m = 1'b1; w(Q); sda_m = 1'b0; w(Q); scl_m = 1'b0; w(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; w(Q); scl_m = 1'b1; w(Q); sda_m = 1'b1; w(2 * Q);
  endtask

  task automatic bit_io(input logic b, output logic r);
    sda_m = b; w(Q); scl_m = 1'b1; w(Q); r = sda_bus; w(Q); scl_m = 1'b0; w(Q);
  endtask

  task automatic wbyte(input logic [7:0] v, output logic ack);
    logic r;
    for (int i = 7; i >= 0; i--) bit_io(v[i], r);
    bit_io(1'b1, r);
    ack = ~r;
  endtask

  task automatic rbyte(input logic nack, output logic [7:0] v);
    logic r;
    for (int i = 0; i < 8; i++) begin bit_io(1'b1, r); v = {v[6:0], r}; end
    bit_io(nack, r);
  endtask

  task automatic do_write(input logic [7:0] b1, input logic [7:0] b2, output logic [2:0] acks);
    bus_start();
    wbyte({ADDR, 1'b0}, acks[2]);
    wbyte(b1, acks[1]);
    wbyte(b2, acks[0]);
    bus_stop();
  endtask

  initial begin
    logic [2:0] acks;
    logic a, r;
    logic [7:0] bt;
    logic [31:0] got;
    logic [8:0] exp_c;
    int base;
    logic [31:0] pats [4] = '{32'hA5C30F81, 32'h00000000, 32'hFFFFFFFF, 32'h01804020};

    w(10); rst_n = 1'b1; w(3);
    chk(ctrl == 9'h0 && !sda_oe && !rearm && rearm_cnt == 0, "R1 reset state",
        {ctrl, sda_oe, rearm}, 0);

    // R5 R6 R3: sweep of the first command byte
    for (int v = 0; v < 128; v++) begin
      logic [7:0] b1, b2;
      b1 = {~v[6], v[6:0]};
      b2 = {6'h2A, v[5:4] ^ v[1:0]};
      base = rearm_cnt;
      do_write(b1, b2, acks);
      exp_c = {b1[6:0], b2[1:0]};
      chk(acks == 3'b111, "R3 R5 R6 acknowledges", acks, 3'b111);
      chk(ctrl == exp_c, "R5 R6 control mapping", ctrl, exp_c);
      chk(rearm_cnt == base, "R10 no pulse after write", rearm_cnt, base);
    end

    // R7: third byte
    bus_start();
    wbyte({ADDR, 1'b0}, a); wbyte(8'h55, a); wbyte(8'h02, a); wbyte(8'h00, a);
    bus_stop();
    chk(!a, "R7 third byte not acked", a, 0);
    chk(ctrl == {7'h55, 2'b10}, "R7 third byte ignored", ctrl, {7'h55, 2'b10});

    // R4: mismatched address, write then read
    base = rearm_cnt;
    bus_start();
    wbyte({ADDR ^ 7'h01, 1'b0}, a);
    chk(!a, "R4 no ack on mismatch", a, 0);
    wbyte(8'h7F, a); wbyte(8'h03, a);
    bus_stop();
    chk(ctrl == {7'h55, 2'b10}, "R4 outputs unchanged", ctrl, {7'h55, 2'b10});
    bus_start();
    wbyte({ADDR ^ 7'h40, 1'b1}, a);
    chk(!a, "R4 no ack on read mismatch", a, 0);
    rbyte(1'b1, bt);
    bus_stop();
    chk(bt == 8'hFF, "R4 bus not driven", bt, 8'hFF);
    chk(rearm_cnt == base, "R4 R10 no pulse on mismatch", rearm_cnt, base);

    // R11 R2: partial byte cut by STOP, then by repeated START
    bus_start();
    wbyte({ADDR, 1'b0}, a);
    for (int i = 0; i < 5; i++) bit_io(1'b1, r);
    bus_stop();
    chk(ctrl == {7'h55, 2'b10}, "R11 partial byte then STOP", ctrl, {7'h55, 2'b10});
    bus_start();
    wbyte({ADDR, 1'b0}, a);
    for (int i = 0; i < 5; i++) bit_io(1'b0, r);
    chk(ctrl == {7'h55, 2'b10}, "R11 partial byte held", ctrl, {7'h55, 2'b10});
    bus_start();
    wbyte({ADDR, 1'b0}, acks[2]); wbyte(8'h2B, acks[1]); wbyte(8'h01, acks[0]);
    bus_stop();
    chk(acks == 3'b111 && ctrl == {7'h2B, 2'b01}, "R2 repeated START restarts",
        {acks, ctrl}, {3'b111, 7'h2B, 2'b01});
    chk(!sda_oe, "R2 released after STOP", sda_oe, 0);

    // R8 R10: four-byte reads with snapshot
    foreach (pats[k]) begin
      base = rearm_cnt;
      diag_status = pats[k];
      bus_start();
      wbyte({ADDR, 1'b1}, a);
      chk(a, "R3 read address acked", a, 1);
      diag_status = ~pats[k];
      for (int j = 0; j < 4; j++) begin
        rbyte(j == 3, bt);
        got = {got[23:0], bt};
      end
      chk(rearm_cnt == base, "R10 no pulse before STOP", rearm_cnt, base);
      bus_stop();
      chk(got == pats[k], "R8 status bytes", got, pats[k]);
      chk(rearm_cnt == base + 1, "R10 one pulse per read", rearm_cnt, base + 1);
      chk(!sda_oe, "R9 released after read", sda_oe, 0);
    end

    // R9: early NACK
    base = rearm_cnt;
    diag_status = 32'h00000000;
    bus_start();
    wbyte({ADDR, 1'b1}, a);
    rbyte(1'b1, bt);
    chk(bt == 8'h00, "R8 first byte", bt, 8'h00);
    rbyte(1'b1, bt);
    chk(bt == 8'hFF, "R9 released after NACK", bt, 8'hFF);
    bus_stop();
    chk(rearm_cnt == base + 1, "R10 pulse after NACKed read", rearm_cnt, base + 1);
    chk(ctrl == {7'h2B, 2'b01}, "R8 read leaves controls", ctrl, {7'h2B, 2'b01});

    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule